// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh Scheduling

This block sits between a simple host request port and a dynamic RAM of one million 4-bit words. The DRAM has multiplexed address pins, a row strobe, a combined column strobe and chip select, and a write strobe. The host offers a 20-bit word address, a read/write flag and 4 bits of write data over a valid/ready handshake. The controller opens the row by driving the upper ten address bits with the row strobe. It then drives the lower ten bits and lowers the column strobe. A read returns its data on a one-cycle response pulse. Every DRAM timing minimum is held as a count of clock cycles, derived from nanosecond parameters and the clock period.

After reset the controller waits out the power-up pause. It then issues eight refresh cycles of the kind where the column strobe falls first, and only after that does it accept host requests. From then on an interval timer asks for one refresh of that kind about every 15.6 us. A pending refresh beats any host request at a cycle boundary. While a row is open, further requests to the same row keep both strobes low and change only the column address (static-column burst). A due refresh, or the limit on how long the row strobe may stay low, ends the burst. Writes are always early writes: the write strobe and the data are set up before the column strobe falls.

Top module: `mxdram_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `dram_ras_n`, `dram_cs_n` and `dram_we_n` are high, and `req_ready` and `rsp_valid` are low.
- R2: After reset, `dram_ras_n` does not fall before 25000 cycles (200 us at 8 ns). `req_ready` first rises only after exactly 8 refresh cycles, with no row activation before them.
- R3: A request's address bits [19:10] are on `dram_addr` when the row strobe falls. Bits [9:0] are on `dram_addr` while the column strobe is low.
- R4: A read returns the 4-bit value most recently written to the same address, or 0 if that address was never written.
- R5: For a write, `dram_we_n` is already low and `dram_dq_oe` already high in the cycle before the column strobe falls. At that fall `dram_we_n` does not change, and whenever a write strobe is low inside an access, `dram_dq_oe` is high.
- R6: A refresh lowers `dram_cs_n` at least one cycle before `dram_ras_n` falls, with `dram_we_n` high for the whole refresh. Refreshes happen only when the scheduler asks for one.
- R7: Every low phase of `dram_ras_n` lasts at least 10 cycles. Every high phase between two low phases lasts at least 9 cycles.
- R8: After power-up, consecutive refreshes start no more than 1950 + 40 cycles apart, whether the host is idle or busy.
- R9: Back-to-back requests to the open row are served in a single row activation. `dram_cs_n` rises only together with `dram_ras_n`.
- R10: A due refresh is served before any further host request, ending any burst. In a long same-row stream, row activations equal 1 plus the refreshes taken, and the row strobe never stays low for 25000 cycles.
- R11: Each accepted read gives exactly one `rsp_valid` pulse, in request order, and writes give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 4 | Read data |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cs_n | output | 1 | Column strobe / chip select, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq_out | output | 4 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 4 | Data from the DRAM |

## Verification
The hardest situation to reach is a refresh falling due in the middle of a static-column burst. The controller must then close the row and refresh before reopening it for the next request. The bench reaches it by streaming several hundred same-row requests back to back, which spans more than one refresh interval. It then checks three things: the number of row activations equals one plus the refreshes taken, the gap between refreshes stays bounded, and every read still matches the scoreboard.

// File: rtl/mxd_pkg.sv
package mxd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RAS,
    S_CSET,
    S_CAS,
    S_PRE,
    S_CBR_CS,
    S_CBR_RAS
  } seq_state_t;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mxd_refresh.sv
module mxd_refresh #(
  parameter int INIT_CYC  = 25000,
  parameter int REF_CYC   = 1950,
  parameter int INIT_REFS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic due,
  output logic init_done
);
  localparam int PW_W = $clog2(INIT_CYC + 1);
  localparam int RF_W = $clog2(REF_CYC + 1);
  localparam int IR_W = $clog2(INIT_REFS + 1);

  logic [PW_W-1:0] pwr_cnt;
  logic            pwr_ok;
  logic [RF_W-1:0] ref_cnt;
  logic [IR_W-1:0] init_left;
  logic            pend;

  wire ref_tick = pwr_ok && (ref_cnt == RF_W'(REF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_cnt   <= '0;
      pwr_ok    <= 1'b0;
      ref_cnt   <= '0;
      init_left <= IR_W'(INIT_REFS);
      pend      <= 1'b0;
    end else begin
      if (!pwr_ok) begin
        pwr_cnt <= pwr_cnt + 1'b1;
        if (pwr_cnt == PW_W'(INIT_CYC - 1)) pwr_ok <= 1'b1;
      end else begin
        ref_cnt <= ref_tick ? '0 : ref_cnt + 1'b1;
      end
      if (ack && init_left != '0) init_left <= init_left - 1'b1;
      if (ref_tick) pend <= 1'b1;
      else if (ack && init_left == '0) pend <= 1'b0;
    end
  end

  assign due       = pwr_ok && (init_left != '0 || pend);
  assign init_done = pwr_ok && (init_left == '0);

  // R6
  ack_when_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> due);
  // R8
  tick_raises_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> due);
  // R2
  quiet_before_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !due && !init_done);

endmodule

// File: rtl/mxd_seq.sv
module mxd_seq
  import mxd_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int DQ_W      = 4,
  parameter int RAS_CYC   = 10,
  parameter int RP_CYC    = 9,
  parameter int RCD_CYC   = 3,
  parameter int SC_CYC    = 7,
  parameter int SCMAX_CYC = 25000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [ROW_W+COL_W-1:0]          req_addr,
  input  logic [DQ_W-1:0]                 req_wdata,
  output logic                            rsp_valid,
  output logic [DQ_W-1:0]                 rsp_rdata,
  input  logic                            ref_due,
  input  logic                            init_done,
  output logic                            ref_ack,
  output logic [max2(ROW_W,COL_W)-1:0]    dram_addr,
  output logic                            dram_ras_n,
  output logic                            dram_cs_n,
  output logic                            dram_we_n,
  output logic [DQ_W-1:0]                 dram_dq_out,
  output logic                            dram_dq_oe,
  input  logic [DQ_W-1:0]                 dram_dq_in
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int DA_W   = max2(ROW_W, COL_W);
  localparam int TMR_W  = $clog2(max2(max2(RAS_CYC, RP_CYC), max2(RCD_CYC, SC_CYC)) + 1);
  localparam int AGE_W  = $clog2(SCMAX_CYC + 1);

  seq_state_t        state;
  logic [TMR_W-1:0]  tmr;
  logic [AGE_W-1:0]  ras_age;   // cycles the row strobe has been low
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_wr;
  logic [DQ_W-1:0]   cur_data;
  logic              rd_pend;

  wire [ROW_W-1:0] req_row = req_addr[ADDR_W-1:COL_W];
  wire [COL_W-1:0] req_col = req_addr[COL_W-1:0];

  // named internal events
  wire tmr_done    = (tmr == '0);
  wire burst_ok    = ras_age < AGE_W'(SCMAX_CYC - SC_CYC - 2);
  wire ras_min_met = ras_age >= AGE_W'(RAS_CYC - 1);
  wire open_ok     = (state == S_IDLE) && init_done && !ref_due;
  wire cont_ok     = (state == S_CAS) && tmr_done && !ref_due && burst_ok && (req_row == cur_row);
  wire fire        = req_valid && req_ready;

  assign req_ready = open_ok || cont_ok;
  assign ref_ack   = (state == S_IDLE) && ref_due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tmr         <= '0;
      ras_age     <= '0;
      cur_row     <= '0;
      cur_col     <= '0;
      cur_wr      <= 1'b0;
      cur_data    <= '0;
      rd_pend     <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cs_n   <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (dram_ras_n) ras_age <= '0;
      else if (ras_age != '1) ras_age <= ras_age + 1'b1;

      unique case (state)
        S_IDLE: begin
          if (ref_due) begin
            dram_cs_n <= 1'b0;
            state     <= S_CBR_CS;
          end else if (fire) begin
            dram_ras_n <= 1'b0;
            dram_addr  <= DA_W'(req_row);
            cur_row    <= req_row;
            cur_col    <= req_col;
            cur_wr     <= req_write;
            cur_data   <= req_wdata;
            tmr        <= TMR_W'(RCD_CYC - 1);
            state      <= S_RAS;
          end
        end
        S_RAS: begin
          if (tmr_done) begin
            dram_addr   <= DA_W'(cur_col);
            dram_we_n   <= !cur_wr;
            dram_dq_oe  <= cur_wr;
            dram_dq_out <= cur_data;
            rd_pend     <= !cur_wr;
            state       <= S_CSET;
          end else tmr <= tmr - 1'b1;
        end
        S_CSET: begin
          dram_cs_n <= 1'b0;
          tmr       <= TMR_W'(SC_CYC - 1);
          state     <= S_CAS;
        end
        S_CAS: begin
          if (!tmr_done) begin
            tmr <= tmr - 1'b1;
            if (cur_wr) dram_we_n <= 1'b0;
          end else begin
            if (rd_pend) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
              rd_pend   <= 1'b0;
            end
            if (fire) begin
              dram_addr   <= DA_W'(req_col);
              dram_we_n   <= 1'b1;
              dram_dq_oe  <= req_write;
              dram_dq_out <= req_wdata;
              cur_wr      <= req_write;
              rd_pend     <= !req_write;
              tmr         <= TMR_W'(SC_CYC - 1);
            end else if (ras_min_met) begin
              dram_ras_n <= 1'b1;
              dram_cs_n  <= 1'b1;
              dram_we_n  <= 1'b1;
              dram_dq_oe <= 1'b0;
              tmr        <= TMR_W'(RP_CYC - 1);
              state      <= S_PRE;
            end
          end
        end
        S_PRE: begin
          if (tmr_done) state <= S_IDLE;
          else tmr <= tmr - 1'b1;
        end
        S_CBR_CS: begin
          dram_ras_n <= 1'b0;
          tmr        <= TMR_W'(RAS_CYC - 1);
          state      <= S_CBR_RAS;
        end
        S_CBR_RAS: begin
          if (tmr_done) begin
            dram_ras_n <= 1'b1;
            dram_cs_n  <= 1'b1;
            tmr        <= TMR_W'(RP_CYC - 1);
            state      <= S_PRE;
          end else tmr <= tmr - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  ras_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> ras_age >= AGE_W'(RAS_CYC));
  // R6
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cs_n) |-> (dram_we_n && $past(!dram_cs_n)));
  // R5
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cs_n) && !dram_ras_n) |-> ($stable(dram_we_n) && (dram_dq_oe == !dram_we_n)));
  // R10
  due_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_due |-> !req_ready);
  // R10
  ras_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> ras_age < AGE_W'(SCMAX_CYC));
  // R2
  no_host_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);
  // R9
  cs_rises_with_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cs_n) |-> $rose(dram_ras_n));

endmodule

// File: rtl/mxdram_ctrl.sv
module mxdram_ctrl
  import mxd_pkg::*;
#(
  parameter int ROW_W      = 10,
  parameter int COL_W      = 10,
  parameter int DQ_W       = 4,
  parameter int CLK_NS     = 8,
  parameter int RAS_NS     = 80,
  parameter int RP_NS      = 70,
  parameter int RCD_NS     = 20,
  parameter int SC_NS      = 55,
  parameter int REF_NS     = 15600,
  parameter int INIT_NS    = 200000,
  parameter int SCMAX_NS   = 200000,
  parameter int INIT_REFS  = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_write,
  input  logic [ROW_W+COL_W-1:0]                 req_addr,
  input  logic [DQ_W-1:0]                        req_wdata,
  output logic                                   rsp_valid,
  output logic [DQ_W-1:0]                        rsp_rdata,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic                                   dram_ras_n,
  output logic                                   dram_cs_n,
  output logic                                   dram_we_n,
  output logic [DQ_W-1:0]                        dram_dq_out,
  output logic                                   dram_dq_oe,
  input  logic [DQ_W-1:0]                        dram_dq_in
);
  localparam int RAS_CYC   = ns2cyc(RAS_NS, CLK_NS);
  localparam int RP_CYC    = ns2cyc(RP_NS, CLK_NS);
  localparam int RCD_CYC   = ns2cyc(RCD_NS, CLK_NS);
  localparam int SC_CYC    = ns2cyc(SC_NS, CLK_NS);
  localparam int REF_CYC   = REF_NS / CLK_NS;     // round down: never late
  localparam int INIT_CYC  = ns2cyc(INIT_NS, CLK_NS);
  localparam int SCMAX_CYC = SCMAX_NS / CLK_NS;

  logic ref_due, ref_ack, init_done;

  mxd_refresh #(
    .INIT_CYC (INIT_CYC),
    .REF_CYC  (REF_CYC),
    .INIT_REFS(INIT_REFS)
  ) u_refresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ref_ack),
    .due      (ref_due),
    .init_done(init_done)
  );

  mxd_seq #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .DQ_W     (DQ_W),
    .RAS_CYC  (RAS_CYC),
    .RP_CYC   (RP_CYC),
    .RCD_CYC  (RCD_CYC),
    .SC_CYC   (SC_CYC),
    .SCMAX_CYC(SCMAX_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .ref_due    (ref_due),
    .init_done  (init_done),
    .ref_ack    (ref_ack),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cs_n  (dram_cs_n),
    .dram_we_n  (dram_we_n),
    .dram_dq_out(dram_dq_out),
    .dram_dq_oe (dram_dq_oe),
    .dram_dq_in (dram_dq_in)
  );

endmodule

// File: tb/mxdram_ctrl_test.sv
module mxdram_ctrl_test;
  // timing restated from the requirements at 8 ns per cycle
  localparam int INIT_CYC  = 25000;   // 200 us
  localparam int REF_CYC   = 1950;    // 15.6 us
  localparam int GAP_SLACK = 40;
  localparam int RAS_CYC   = 10;
  localparam int RP_CYC    = 9;
  localparam int INIT_REFS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [3:0] rsp_rdata;
  logic [9:0] dram_addr;
  logic dram_ras_n, dram_cs_n, dram_we_n, dram_dq_oe;
  logic [3:0] dram_dq_out;
  logic [3:0] dram_dq_in = '0;

  always #4 clk = ~clk;

  mxdram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cs_n(dram_cs_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // ---------------- DRAM model and protocol monitor ----------------
  logic [3:0] model_mem [int];
  logic [3:0] shadow [int];
  logic [3:0] exp_q [$];
  logic [9:0] row_q = '0;
  bit prev_ras = 1, prev_cs = 1, prev_we = 1, in_cbr = 0, seen_ras = 0;
  int cyc = 0, ras_lo_cnt = 0, ras_hi_cnt = 0;
  int n_cbr = 0, n_act = 0, last_cbr = -1, n_gap = 0, first_ras_cyc = -1;
  int v_rp = 0, v_ras = 0, v_cbr = 0, v_early = 0, v_gap = 0, v_cs = 0;
  bit ready_seen = 0;
  int cbr_at_ready = -1, act_at_ready = -1;

  function automatic logic [3:0] peek(input int k);
    return model_mem.exists(k) ? model_mem[k] : 4'h0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_ras && !dram_ras_n) begin
        if (seen_ras && ras_hi_cnt < RP_CYC) v_rp++;
        seen_ras = 1;
        if (first_ras_cyc < 0) first_ras_cyc = cyc;
        ras_lo_cnt = 0;
        if (!dram_cs_n) begin
          in_cbr = 1;
          n_cbr++;
          if (prev_cs) v_cbr++;
          if (last_cbr >= 0) begin
            n_gap++;
            if (cyc - last_cbr > REF_CYC + GAP_SLACK) v_gap++;
          end
          last_cbr = cyc;
        end else begin
          in_cbr = 0;
          n_act++;
          row_q = dram_addr;
        end
      end
      if (!prev_ras && dram_ras_n) begin
        if (ras_lo_cnt < RAS_CYC) v_ras++;
        ras_hi_cnt = 0;
        in_cbr = 0;
      end
      if (!dram_ras_n) ras_lo_cnt++; else ras_hi_cnt++;
      if (in_cbr && !dram_ras_n && !dram_we_n) v_cbr++;
      if (!dram_ras_n && !in_cbr && prev_cs && !dram_cs_n && (dram_we_n != prev_we)) v_early++;
      if (!prev_cs && dram_cs_n && !dram_ras_n) v_cs++;
      if (!dram_ras_n && !dram_cs_n && !in_cbr && !dram_we_n) begin
        if (!dram_dq_oe) v_early++;
        model_mem[int'({row_q, dram_addr})] = dram_dq_out;
      end
      dram_dq_in = (!dram_ras_n && !dram_cs_n && dram_we_n && !in_cbr)
                   ? peek(int'({row_q, dram_addr})) : 4'h0;
      if (req_ready && !ready_seen) begin
        ready_seen = 1;
        cbr_at_ready = n_cbr;
        act_at_ready = n_act;
      end
      prev_ras = dram_ras_n;
      prev_cs  = dram_cs_n;
      prev_we  = dram_we_n;
    end
  end

  // ---------------- scoreboard monitor ----------------
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R11", "response with nothing outstanding", 1, 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check(rsp_rdata == e, "R4", "read data", rsp_rdata, e);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(input bit wr, input logic [19:0] a, input logic [3:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (wr) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual 1 expected 0");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [19:0] wa [4];
    logic [3:0]  wd [4];
    int a0, c0;
    wa = '{20'hA53C7, 20'h0F3FF, 20'hFFC01, 20'h5A2A5};
    wd = '{4'h9, 4'h6, 4'hF, 4'h3};

    idle(3);
    // R1 reset state
    check(dram_ras_n && dram_cs_n && dram_we_n, "R1", "strobes high in reset",
          {dram_ras_n, dram_cs_n, dram_we_n}, 7);
    check(!req_ready && !rsp_valid, "R1", "ready/rsp low in reset", {req_ready, rsp_valid}, 0);
    #2 rst_n = 1;
    @(negedge clk);
    check(dram_ras_n && dram_cs_n && !req_ready, "R1", "idle after reset release",
          {dram_ras_n, dram_cs_n, req_ready}, 6);

    // R2 power-up sequence
    while (!ready_seen) @(negedge clk);
    check(first_ras_cyc >= INIT_CYC, "R2", "first row strobe cycle", first_ras_cyc, INIT_CYC);
    check(cbr_at_ready == INIT_REFS, "R2", "refreshes before ready", cbr_at_ready, INIT_REFS);
    check(act_at_ready == 0, "R2", "activations before ready", act_at_ready, 0);

    // R3/R4 isolated writes and reads, distinct row and column halves
    for (int i = 0; i < 4; i++) begin do_req(1, wa[i], wd[i]); idle(30); end
    for (int i = 0; i < 4; i++) begin
      check(model_mem.exists(int'(wa[i])) && model_mem[int'(wa[i])] == wd[i], "R3",
            "row/column split stores at its own address", int'(peek(int'(wa[i]))), int'(wd[i]));
    end
    for (int i = 3; i >= 0; i--) begin do_req(0, wa[i], 4'h0); idle(30); end
    do_req(0, 20'h12345, 4'h0);   // never written, R4 expects 0
    idle(40);

    // R9 static-column burst in one row, mixed writes and reads
    a0 = n_act; c0 = n_cbr;
    for (int i = 0; i < 16; i++) do_req(1, {10'h155, 10'(i * 37)}, 4'(i ^ 5));
    for (int i = 15; i >= 0; i--) do_req(0, {10'h155, 10'(i * 37)}, 4'h0);
    idle(40);
    check(n_act - a0 == 1 + (n_cbr - c0), "R9", "activations in burst",
          n_act - a0, 1 + (n_cbr - c0));

    // R10 long same-row stream crossing refresh intervals
    a0 = n_act; c0 = n_cbr;
    for (int i = 0; i < 600; i++) begin
      if (i % 3 == 2) do_req(0, {10'h2C3, 10'(i - 1)}, 4'h0);
      else do_req(1, {10'h2C3, 10'(i)}, 4'(i));
    end
    idle(40);
    check(n_cbr - c0 >= 1, "R10", "refreshes taken during stream", n_cbr - c0, 1);
    check(n_act - a0 == 1 + (n_cbr - c0), "R10", "reopen after each refresh",
          n_act - a0, 1 + (n_cbr - c0));

    // R8 idle host: refreshes keep coming
    c0 = n_cbr;
    idle(4500);
    check(n_cbr - c0 >= 2, "R8", "refreshes while idle", n_cbr - c0, 2);

    // mixed traffic over two rows
    for (int i = 0; i < 150; i++) begin
      logic [19:0] a;
      a = {10'(10'd40 + 10'($urandom_range(0, 1))), 10'($urandom_range(0, 63))};
      do_req(1'($urandom_range(0, 1)), a, 4'($urandom_range(0, 15)));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 20));
    end
    idle(60);

    check(exp_q.size() == 0, "R11", "outstanding reads", exp_q.size(), 0);
    check(v_rp == 0, "R7", "short precharge count", v_rp, 0);
    check(v_ras == 0, "R7", "short row strobe count", v_ras, 0);
    check(v_cbr == 0, "R6", "refresh order/write strobe violations", v_cbr, 0);
    check(v_early == 0, "R5", "early write violations", v_early, 0);
    check(v_cs == 0, "R9", "column strobe rose inside open row", v_cs, 0);
    check(v_gap == 0 && n_gap > 10, "R8", "refresh gaps over limit", v_gap, 0);
    done = 1;
    finish_run();
  end

endmodule